// File: doc/BRIEF.md
# Single-Wire Echoing Debug Monitor Port

This block is a debug access port that runs on a single open-drain data line. A host sends asynchronous bytes. Each byte has one low start bit, eight data bits with the least significant bit first, and one high stop bit. The port sends every byte it receives straight back on the same line, so the host can compare what it sent against what came back. The port only pulls the line low. An external pull-up makes every high level, and the incoming level passes through a two-flop synchronizer.

One command is decoded: a memory read. The host sends the read opcode, then the high address byte, then the low address byte, and each of these is echoed. When the echo of the low address byte has finished, the port pulses a read strobe on a synchronous memory port. It then sends the returned data byte as one more frame.

A frame whose stop bit is missing counts as a break. The port answers a break by leaving the line released for two bit times and then sending an all-zero frame. A break also drops any command that was only partly received.

Top module: `monitor_port`

## Requirements
- R1: While reset is asserted and right after it is released, `pin_oe_o` is 0, `mem_rd_o` is 0 and `mem_addr_o` is 0.
- R2: Every frame the port transmits is BIT_CYC clocks per bit: a start bit (pin_oe_o=1), eight data bits with the least significant first (pin_oe_o=1 for a 0 bit, 0 for a 1 bit), and a stop bit (pin_oe_o=0). The pin is never driven high.
- R3: Each correctly framed byte is echoed exactly once. The echo's start bit begins between 9.5 and 10 bit times after the falling edge of the received start bit.
- R4: The sequence READ_OP, high byte H, low byte L causes exactly one `mem_rd_o` pulse, with `mem_addr_o` = {H, L} while the strobe is high.
- R5: The read strobe comes only after the echo of L has finished. The data captured one clock after the strobe is then sent as a frame whose start bit begins between 10 bit times and 10 bit times plus 6 clocks after the start of L's echo.
- R6: A first byte other than READ_OP is echoed and causes no read, and neither do the bytes that follow it.
- R7: A low pulse shorter than half a bit time gives no echo, and the receiver stays able to take the next byte.
- R8: A start bit followed by nine low bit times (stop bit missing) is a break. It is answered by an all-zero frame whose start bit begins between 11.5 and 12 bit times after the start of the break, so the line stays released for at least two bit times after the break is detected.
- R9: A break received after only part of a read command drops that command. A complete read command sent next produces a read at its own address, and only one read in total.
- R10: The receiver is disabled while the port transmits and while a read result is pending. The port never takes its own frames as input, and it never drives the line while the host is pulling it low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pin_i | input | 1 | Level sampled on the shared data line |
| pin_oe_o | output | 1 | Pulls the data line low when 1 |
| mem_addr_o | output | 16 | Read address |
| mem_rd_o | output | 1 | Single-cycle read strobe |
| mem_data_i | input | 8 | Read data, valid one clock after the strobe |

## Verification
The bench builds the port with BIT_CYC = 16 and READ_OP = 0x4A. A full frame therefore takes 160 clocks, and a break, its two-bit hold and the zero echo fit in a few hundred clocks. The short bit time lets the bench measure echo delays, the gap before the result and the break hold down to single clocks. It also keeps glitches of a quarter bit, broken commands and several full read transactions well inside a short run.

// File: rtl/monitor_pkg.sv
package monitor_pkg;
  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_state_e;
  typedef enum logic [2:0] {TX_IDLE, TX_HOLD, TX_START, TX_DATA, TX_STOP} tx_state_e;
  typedef enum logic [2:0] {CM_IDLE, CM_HI, CM_LO, CM_ECHO, CM_READ, CM_SEND} cmd_state_e;
endpackage

// File: rtl/monitor_sync.sv
module monitor_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= '1;  // idle line is high
    else         q <= {q[STAGES-2:0], d_i};
  end

  assign q_o = q[STAGES-1];
endmodule

// File: rtl/monitor_rx.sv
module monitor_rx
  import monitor_pkg::*;
#(
  parameter int BIT_CYC = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic       rx_i,
  output logic       byte_v_o,
  output logic [7:0] byte_o,
  output logic       brk_o,
  output logic       busy_o
);
  localparam int CNT_W = $clog2(BIT_CYC + 1);
  localparam int HALF  = BIT_CYC / 2;

  rx_state_e        st;
  logic [CNT_W-1:0] cnt;
  logic [2:0]       idx;
  logic             prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st       <= RX_IDLE;
      cnt      <= '0;
      idx      <= '0;
      prev_q   <= 1'b1;
      byte_o   <= '0;
      byte_v_o <= 1'b0;
      brk_o    <= 1'b0;
    end else begin
      prev_q   <= rx_i;
      byte_v_o <= 1'b0;
      brk_o    <= 1'b0;
      if (!en_i) begin
        st <= RX_IDLE;
      end else begin
        case (st)
          RX_IDLE: if (prev_q && !rx_i) begin
            cnt <= CNT_W'(HALF - 1);
            st  <= RX_START;
          end
          RX_START: if (cnt == '0) begin
            if (!rx_i) begin  // still low at mid-bit: genuine start
              cnt <= CNT_W'(BIT_CYC - 1);
              idx <= '0;
              st  <= RX_DATA;
            end else begin
              st <= RX_IDLE;
            end
          end else cnt <= cnt - 1'b1;
          RX_DATA: if (cnt == '0) begin
            byte_o <= {rx_i, byte_o[7:1]};
            cnt    <= CNT_W'(BIT_CYC - 1);
            idx    <= idx + 1'b1;
            if (idx == 3'd7) st <= RX_STOP;
          end else cnt <= cnt - 1'b1;
          RX_STOP: if (cnt == '0) begin
            st <= RX_IDLE;
            if (rx_i) byte_v_o <= 1'b1;
            else      brk_o    <= 1'b1;  // missing stop bit
          end else cnt <= cnt - 1'b1;
          default: st <= RX_IDLE;
        endcase
      end
    end
  end

  assign busy_o = (st != RX_IDLE);
endmodule

// File: rtl/monitor_tx.sv
module monitor_tx
  import monitor_pkg::*;
#(
  parameter int BIT_CYC = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic [7:0] data_i,
  input  logic       hold_i,
  output logic       oe_o,
  output logic       busy_o,
  output logic       done_o
);
  localparam int CNT_W = $clog2(2 * BIT_CYC + 1);

  tx_state_e        st;
  logic [CNT_W-1:0] cnt;
  logic [2:0]       idx;
  logic [7:0]       sh;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st  <= TX_IDLE;
      cnt <= '0;
      idx <= '0;
      sh  <= '0;
    end else begin
      case (st)
        TX_IDLE: if (start_i) begin
          sh  <= data_i;
          idx <= '0;
          if (hold_i) begin
            cnt <= CNT_W'(2 * BIT_CYC - 1);
            st  <= TX_HOLD;
          end else begin
            cnt <= CNT_W'(BIT_CYC - 1);
            st  <= TX_START;
          end
        end
        TX_HOLD: if (cnt == '0) begin
          cnt <= CNT_W'(BIT_CYC - 1);
          st  <= TX_START;
        end else cnt <= cnt - 1'b1;
        TX_START: if (cnt == '0) begin
          cnt <= CNT_W'(BIT_CYC - 1);
          st  <= TX_DATA;
        end else cnt <= cnt - 1'b1;
        TX_DATA: if (cnt == '0) begin
          sh  <= sh >> 1;
          cnt <= CNT_W'(BIT_CYC - 1);
          idx <= idx + 1'b1;
          if (idx == 3'd7) st <= TX_STOP;
        end else cnt <= cnt - 1'b1;
        TX_STOP: if (cnt == '0) st <= TX_IDLE;
                 else cnt <= cnt - 1'b1;
        default: st <= TX_IDLE;
      endcase
    end
  end

  assign oe_o   = (st == TX_START) || (st == TX_DATA && !sh[0]);
  assign busy_o = (st != TX_IDLE);
  assign done_o = (st == TX_STOP) && (cnt == '0);
endmodule

// File: rtl/monitor_cmd.sv
module monitor_cmd
  import monitor_pkg::*;
#(
  parameter logic [7:0] READ_OP = 8'h4A
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        byte_v_i,
  input  logic [7:0]  byte_i,
  input  logic        brk_i,
  input  logic        tx_done_i,
  input  logic [7:0]  mem_data_i,
  output logic        rd_o,
  output logic [15:0] addr_o,
  output logic        res_start_o,
  output logic [7:0]  res_data_o,
  output logic        hold_o
);
  cmd_state_e st;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st     <= CM_IDLE;
      addr_o <= '0;
    end else if (brk_i) begin
      st <= CM_IDLE;  // break drops a partial command
    end else begin
      case (st)
        CM_IDLE: if (byte_v_i && byte_i == READ_OP) st <= CM_HI;
        CM_HI:   if (byte_v_i) begin addr_o[15:8] <= byte_i; st <= CM_LO; end
        CM_LO:   if (byte_v_i) begin addr_o[7:0]  <= byte_i; st <= CM_ECHO; end
        CM_ECHO: if (tx_done_i) st <= CM_READ;
        CM_READ: st <= CM_SEND;
        CM_SEND: st <= CM_IDLE;
        default: st <= CM_IDLE;
      endcase
    end
  end

  assign rd_o        = (st == CM_READ);
  assign res_start_o = (st == CM_SEND);
  assign res_data_o  = mem_data_i;
  assign hold_o      = (st == CM_ECHO) || (st == CM_READ) || (st == CM_SEND);
endmodule

// File: rtl/monitor_port.sv
module monitor_port
  import monitor_pkg::*;
#(
  parameter int         BIT_CYC = 16,
  parameter logic [7:0] READ_OP = 8'h4A
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        pin_i,
  output logic        pin_oe_o,
  output logic [15:0] mem_addr_o,
  output logic        mem_rd_o,
  input  logic [7:0]  mem_data_i
);
  logic       rx_s, rx_en, rx_busy;
  logic       byte_v, brk;
  logic [7:0] rx_byte, res_data, tx_data;
  logic       res_start, cmd_hold;
  logic       tx_start, tx_busy, tx_done;

  monitor_sync #(.STAGES(2)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(pin_i), .q_o(rx_s)
  );

  assign rx_en = !tx_busy && !cmd_hold;

  monitor_rx #(.BIT_CYC(BIT_CYC)) u_rx (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(rx_en), .rx_i(rx_s),
    .byte_v_o(byte_v), .byte_o(rx_byte), .brk_o(brk), .busy_o(rx_busy)
  );

  monitor_cmd #(.READ_OP(READ_OP)) u_cmd (
    .clk_i(clk_i), .rst_ni(rst_ni), .byte_v_i(byte_v), .byte_i(rx_byte),
    .brk_i(brk), .tx_done_i(tx_done), .mem_data_i(mem_data_i),
    .rd_o(mem_rd_o), .addr_o(mem_addr_o), .res_start_o(res_start),
    .res_data_o(res_data), .hold_o(cmd_hold)
  );

  assign tx_start = byte_v || brk || res_start;
  assign tx_data  = brk ? 8'h00 : (res_start ? res_data : rx_byte);

  monitor_tx #(.BIT_CYC(BIT_CYC)) u_tx (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(tx_start), .data_i(tx_data),
    .hold_i(brk), .oe_o(pin_oe_o), .busy_o(tx_busy), .done_o(tx_done)
  );
endmodule

// File: rtl/monitor_port_sva.sv
module monitor_port_sva (
  input logic clk_i,
  input logic rst_ni,
  input logic pin_oe_i,
  input logic mem_rd_i,
  input logic tx_busy_i,
  input logic tx_start_i,
  input logic tx_done_i,
  input logic rx_busy_i
);
  p_release_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_busy_i |-> !pin_oe_i);
  p_start_idle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_start_i |-> !tx_busy_i);
  p_rd_after_echo_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rd_i |-> $past(tx_done_i));
  p_rd_pulse_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rd_i |=> !mem_rd_i);
  p_result_sent_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rd_i |-> ##2 tx_busy_i);
  p_rx_off_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_busy_i |-> !rx_busy_i);
endmodule

bind monitor_port monitor_port_sva u_sva (
  .clk_i(clk_i), .rst_ni(rst_ni), .pin_oe_i(pin_oe_o), .mem_rd_i(mem_rd_o),
  .tx_busy_i(tx_busy), .tx_start_i(tx_start), .tx_done_i(tx_done),
  .rx_busy_i(rx_busy)
);

// File: tb/tb_monitor_port.sv
module tb_monitor_port;
  localparam int CLK_PERIOD = 10;
  localparam int B = 16;
  localparam logic [7:0] OP = 8'h4A;

  logic clk = 1'b0, rst_n = 1'b0, host_low = 1'b0;
  logic pin, oe, rd;
  logic [15:0] addr;
  logic [7:0]  mdata = 8'h00;
  int total = 0, bad = 0, cyc = 0, rd_cnt = 0;
  logic [15:0] last_addr = '0;
  logic [7:0] fq[$];
  int ft[$];
  int sq[$];

  always #(CLK_PERIOD/2) clk = ~clk;
  assign pin = !(host_low || oe);

  monitor_port #(.BIT_CYC(B), .READ_OP(OP)) dut (
    .clk_i(clk), .rst_ni(rst_n), .pin_i(pin), .pin_oe_o(oe),
    .mem_addr_o(addr), .mem_rd_o(rd), .mem_data_i(mdata)
  );

  function automatic logic [7:0] mf(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'hA5;
  endfunction

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rd) begin
      mdata <= mf(addr);
      rd_cnt = rd_cnt + 1;
      last_addr = addr;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // R10: never drive while the host pulls low
  always @(negedge clk) if (rst_n) chk(!(host_low && oe), "R10 contention", oe, 0);

  // line-side decoder of frames sent by the port (R2)
  initial begin
    logic prev;
    prev = 1'b0;
    forever begin
      @(negedge clk);
      if (oe && !prev) begin
        logic [7:0] b;
        int t;
        bit ok;
        t = cyc;
        ok = 1;
        repeat (B/2) @(negedge clk);
        if (!oe) ok = 0;
        for (int i = 0; i < 8; i++) begin
          repeat (B) @(negedge clk);
          b[i] = !oe;
        end
        repeat (B) @(negedge clk);
        if (oe) ok = 0;
        chk(ok, "R2 frame format", ok, 1);
        fq.push_back(b);
        ft.push_back(t);
      end
      prev = oe;
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] v);
    @(negedge clk);
    sq.push_back(cyc);
    host_low = 1'b1;
    idle(B);
    for (int i = 0; i < 8; i++) begin
      host_low = !v[i];
      idle(B);
    end
    host_low = 1'b0;
    idle(B);
    idle(22 * B);
  endtask

  task automatic send_break();
    @(negedge clk);
    sq.push_back(cyc);
    host_low = 1'b1;
    idle(10 * B);
    host_low = 1'b0;
    idle(24 * B);
  endtask

  task automatic clear();
    fq.delete(); ft.delete(); sq.delete();
    rd_cnt = 0;
  endtask

  task automatic chk_frames(input string tag, input logic [7:0] e[]);
    chk(fq.size() == e.size(), {tag, " frame count"}, fq.size(), e.size());
    for (int i = 0; i < e.size(); i++)
      if (i < fq.size()) chk(fq[i] == e[i], {tag, " byte"}, fq[i], e[i]);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int d;
    idle(3);
    chk(oe == 0, "R1 oe in reset", oe, 0);
    chk(rd == 0, "R1 rd in reset", rd, 0);
    rst_n = 1'b1;
    idle(2);
    chk(oe == 0, "R1 oe after reset", oe, 0);
    chk(rd == 0 && addr == 0, "R1 rd/addr after reset", addr, 0);
    idle(B);

    // R3 single echo and its delay
    clear();
    send(8'h5A);
    chk_frames("R3 echo 5A", '{8'h5A});
    if (ft.size() > 0) begin
      d = ft[0] - sq[0];
      chk(d >= B*19/2 && d <= 10*B, "R3 echo delay", d, B*19/2);
    end

    // R2 LSB-first patterns
    clear();
    send(8'hFF); send(8'h01); send(8'h80); send(8'hC3);
    chk_frames("R2 patterns", '{8'hFF, 8'h01, 8'h80, 8'hC3});

    // R4 R5 read command
    clear();
    send(OP); send(8'h12); send(8'h34);
    chk_frames("R4 read 1234", '{OP, 8'h12, 8'h34, mf(16'h1234)});
    chk(rd_cnt == 1, "R4 strobe count", rd_cnt, 1);
    chk(last_addr == 16'h1234, "R4 address", last_addr, 16'h1234);
    if (ft.size() == 4) begin
      d = ft[3] - ft[2];
      chk(d >= 10*B && d <= 10*B + 6, "R5 result gap", d, 10*B);
    end

    clear();
    send(OP); send(8'hAB); send(8'hCD);
    chk_frames("R4 read ABCD", '{OP, 8'hAB, 8'hCD, mf(16'hABCD)});
    chk(last_addr == 16'hABCD && rd_cnt == 1, "R4 address 2", last_addr, 16'hABCD);

    // R6 other opcode
    clear();
    send(8'h33); send(8'h12); send(8'h34);
    chk_frames("R6 other op", '{8'h33, 8'h12, 8'h34});
    chk(rd_cnt == 0, "R6 no read", rd_cnt, 0);

    // R7 glitch
    clear();
    @(negedge clk);
    host_low = 1'b1;
    idle(B/4);
    host_low = 1'b0;
    idle(24 * B);
    chk(fq.size() == 0, "R7 glitch ignored", fq.size(), 0);
    clear();
    send(8'h21);
    chk_frames("R7 rx after glitch", '{8'h21});

    // R8 break
    clear();
    send_break();
    chk_frames("R8 break echo", '{8'h00});
    if (ft.size() > 0) begin
      d = ft[0] - sq[0];
      chk(d >= B*23/2 && d <= 12*B + 2, "R8 break delay", d, B*23/2);
    end

    // R9 break aborts partial command
    clear();
    send(OP); send(8'h12); send_break();
    send(OP); send(8'h00); send(8'h10);
    chk_frames("R9 abort", '{OP, 8'h12, 8'h00, OP, 8'h00, 8'h10, mf(16'h0010)});
    chk(rd_cnt == 1, "R9 single read", rd_cnt, 1);
    chk(last_addr == 16'h0010, "R9 address", last_addr, 16'h0010);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule